// File: doc/BRIEF.md
# Correlating Two-Level Branch Direction Predictor

This block guesses whether a conditional branch will be taken. A table of 2-bit saturating counters is arranged in rows. A few low bits of the branch address pick the row. A short shift register holding the outcomes of the most recent branches, from any address, picks one counter inside that row. The top bit of that counter is the guess. No address tag is kept, so branches whose index bits match share counters.

The fetch side presents an address on the lookup port and gets a direction and the current history value back in the same cycle. It keeps that history value with the branch. When the branch resolves, the execute side returns the branch address, the saved history value and the real outcome on the update port. Only the counter picked by that address and that saved history moves one step towards the outcome. The outcome is also shifted into the global history. A lookup and an update may arrive in the same cycle.

Top module: `corr_branch_predictor`

## Requirements
- R1: After reset every counter holds 01 (weakly not taken), so every lookup predicts not taken, and the history register reads 0.
- R2: The row is `pc[IDX_BITS+PC_LSB-1:PC_LSB]` (bits 7:2 by default) and the column is the current history value. `predTaken` is bit 1 of the counter at {row, column}. Counter codes: 00 strong not taken, 01 weak not taken, 10 weak taken, 11 strong taken.
- R3: An update with `updTaken`=1 raises the chosen counter by one, and it stays at 11 once it is there.
- R4: An update with `updTaken`=0 lowers the chosen counter by one, and it stays at 00 once it is there.
- R5: An update changes only the counter whose row comes from `updPc` and whose column comes from `updHist`. Every other counter keeps its value.
- R6: On each update the history shifts left by one and the outcome enters bit 0 (1 = taken). Without an update the history holds its value. `predHist` shows the history register.
- R7: Starting from a strong state, the prediction changes only after two updates against it in a row.
- R8: No tag is compared. Addresses that differ only outside the index bits use the same counters.
- R9: When a lookup and an update happen in the same cycle, the lookup returns the value from before the update. The update becomes visible from the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| lookupPc | input | PC_BITS | Address of the branch being fetched |
| predTaken | output | 1 | Predicted direction, 1 = taken |
| predHist | output | HIST_BITS | History value used for this lookup; the caller keeps it with the branch |
| updValid | input | 1 | A resolved branch is being reported |
| updPc | input | PC_BITS | Address of the resolved branch |
| updHist | input | HIST_BITS | History value that was captured when this branch was predicted |
| updTaken | input | 1 | Real outcome of the resolved branch, 1 = taken |

## Verification
The assertions assume three things about the inputs:
- Reset is held low across at least one rising edge before any update arrives.
- The update inputs carry known values once reset is released.
- `updHist` is whatever history value the caller captured.

The stimulus holds reset for two cycles. It drives every input at the falling edge. Most updates return the history seen at the matching lookup. Some use an arbitrary in-range value, to exercise counters that the current pattern would not reach. The pool of branch addresses is small and includes pairs that differ only above the index bits, so aliasing and saturation are reached often.

// File: rtl/bp_pkg.sv
package bp_pkg;

  // Commands from the update control to the counter/history datapath
  typedef struct packed {
    logic cntInc;     // step the addressed counter up by one
    logic cntDec;     // step the addressed counter down by one
    logic histShift;  // shift an outcome into the global history
    logic histBit;    // the outcome to shift in
  } bpStrobes_t;

endpackage

// File: rtl/bp_ctrl.sv
module bp_ctrl
  import bp_pkg::*;
#(
  parameter int CNT_BITS = 2
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                updValid,
  input  logic                updTaken,
  input  logic [CNT_BITS-1:0] updCnt,
  output bpStrobes_t          strobes
);

  localparam logic [CNT_BITS-1:0] CNT_MAX = {CNT_BITS{1'b1}};
  localparam logic [CNT_BITS-1:0] CNT_MIN = '0;

  always_comb begin
    strobes           = '0;
    strobes.histShift = updValid;
    strobes.histBit   = updTaken;
    // saturation is handled here, so the datapath never wraps around
    strobes.cntInc    = updValid &&  updTaken && (updCnt != CNT_MAX);
    strobes.cntDec    = updValid && !updTaken && (updCnt != CNT_MIN);
  end

  // R5: at most one counter command per cycle
  assert_single_cmd_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({strobes.cntInc, strobes.cntDec}));

  // R3/R4: no command is issued unless an update is present
  assert_cmd_needs_update_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !updValid |-> !(strobes.cntInc || strobes.cntDec || strobes.histShift));

endmodule

// File: rtl/bp_table.sv
module bp_table
  import bp_pkg::*;
#(
  parameter int PC_BITS   = 32,
  parameter int PC_LSB    = 2,
  parameter int IDX_BITS  = 6,
  parameter int HIST_BITS = 2,
  parameter int CNT_BITS  = 2
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [PC_BITS-1:0]   lookupPc,
  input  logic [PC_BITS-1:0]   updPc,
  input  logic [HIST_BITS-1:0] updHist,
  input  bpStrobes_t           strobes,
  output logic                 predTaken,
  output logic [CNT_BITS-1:0]  updCnt,
  output logic [HIST_BITS-1:0] histQ
);

  localparam int ENT_W   = IDX_BITS + HIST_BITS;
  localparam int ENTRIES = 1 << ENT_W;
  localparam logic [CNT_BITS-1:0] CNT_INIT = CNT_BITS'((1 << (CNT_BITS - 1)) - 1);
  localparam logic [CNT_BITS-1:0] CNT_ONE  = CNT_BITS'(1);

  logic [CNT_BITS-1:0] cntTbl [ENTRIES];
  logic [ENT_W-1:0]    lookupIdx;
  logic [ENT_W-1:0]    wrIdx;

  // the address picks the row, the history picks the column inside it
  assign lookupIdx = {lookupPc[PC_LSB +: IDX_BITS], histQ};
  assign wrIdx     = {updPc[PC_LSB +: IDX_BITS], updHist};

  assign predTaken = cntTbl[lookupIdx][CNT_BITS-1];
  assign updCnt    = cntTbl[wrIdx];

  // the remaining address bits are ignored on purpose: there is no tag
  logic unusedPcBits;
  assign unusedPcBits = ^{lookupPc[PC_BITS-1:PC_LSB+IDX_BITS], lookupPc[PC_LSB-1:0],
                          updPc[PC_BITS-1:PC_LSB+IDX_BITS], updPc[PC_LSB-1:0]};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < ENTRIES; i++) cntTbl[i] <= CNT_INIT;
    end else if (strobes.cntInc) begin
      cntTbl[wrIdx] <= cntTbl[wrIdx] + CNT_ONE;
    end else if (strobes.cntDec) begin
      cntTbl[wrIdx] <= cntTbl[wrIdx] - CNT_ONE;
    end
  end

  // the history width decides whether there is anything to shift
  generate
    if (HIST_BITS == 1) begin : g_hist1
      always_ff @(posedge clk) begin
        if (!rst_n)                 histQ <= '0;
        else if (strobes.histShift) histQ <= strobes.histBit;
      end
    end else begin : g_histN
      always_ff @(posedge clk) begin
        if (!rst_n)                 histQ <= '0;
        else if (strobes.histShift) histQ <= {histQ[HIST_BITS-2:0], strobes.histBit};
      end
    end
  endgenerate

  // R3: a raise moves the addressed counter up by exactly one
  assert_inc_step_R3: assert property (@(posedge clk) disable iff (!rst_n)
    strobes.cntInc |=> cntTbl[$past(wrIdx)] == $past(cntTbl[wrIdx]) + CNT_ONE);

  // R4: a lower moves the addressed counter down by exactly one
  assert_dec_step_R4: assert property (@(posedge clk) disable iff (!rst_n)
    strobes.cntDec |=> cntTbl[$past(wrIdx)] == $past(cntTbl[wrIdx]) - CNT_ONE);

  // R5: with no counter command, the entry under lookup keeps its value
  assert_no_cmd_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !(strobes.cntInc || strobes.cntDec) |=> cntTbl[$past(lookupIdx)] == $past(cntTbl[lookupIdx]));

  // R6: the outcome lands in bit 0 after a shift
  assert_hist_newest_R6: assert property (@(posedge clk) disable iff (!rst_n)
    strobes.histShift |=> histQ[0] == $past(strobes.histBit));

  // R6: the history holds when nothing resolves
  assert_hist_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !strobes.histShift |=> $stable(histQ));

endmodule

// File: rtl/corr_branch_predictor.sv
module corr_branch_predictor
  import bp_pkg::*;
#(
  parameter int PC_BITS   = 32,
  parameter int PC_LSB    = 2,
  parameter int IDX_BITS  = 6,
  parameter int HIST_BITS = 2,
  parameter int CNT_BITS  = 2
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [PC_BITS-1:0]   lookupPc,
  output logic                 predTaken,
  output logic [HIST_BITS-1:0] predHist,
  input  logic                 updValid,
  input  logic [PC_BITS-1:0]   updPc,
  input  logic [HIST_BITS-1:0] updHist,
  input  logic                 updTaken
);

  bpStrobes_t          strobes;
  logic [CNT_BITS-1:0] updCnt;

  bp_ctrl #(.CNT_BITS(CNT_BITS)) i_ctrl (
    .clk      (clk),
    .rst_n    (rst_n),
    .updValid (updValid),
    .updTaken (updTaken),
    .updCnt   (updCnt),
    .strobes  (strobes)
  );

  bp_table #(
    .PC_BITS   (PC_BITS),
    .PC_LSB    (PC_LSB),
    .IDX_BITS  (IDX_BITS),
    .HIST_BITS (HIST_BITS),
    .CNT_BITS  (CNT_BITS)
  ) i_table (
    .clk       (clk),
    .rst_n     (rst_n),
    .lookupPc  (lookupPc),
    .updPc     (updPc),
    .updHist   (updHist),
    .strobes   (strobes),
    .predTaken (predTaken),
    .updCnt    (updCnt),
    .histQ     (predHist)
  );

endmodule

// File: tb/test_corr_branch_predictor.sv
`timescale 1ns/1ps
module test_corr_branch_predictor;

  localparam int ROWS = 64;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] lookupPc = '0;
  logic        predTaken;
  logic [1:0]  predHist;
  logic        updValid = 1'b0;
  logic [31:0] updPc = '0;
  logic [1:0]  updHist = '0;
  logic        updTaken = 1'b0;

  int checkCnt = 0;
  int failCnt = 0;
  bit summaryDone = 0;

  // reference model, built from the requirements
  logic [1:0] expTbl [ROWS*4];
  logic [1:0] expHist;

  always #4 clk = ~clk;

  corr_branch_predictor i_corr_branch_predictor (
    .clk(clk), .rst_n(rst_n), .lookupPc(lookupPc), .predTaken(predTaken),
    .predHist(predHist), .updValid(updValid), .updPc(updPc), .updHist(updHist),
    .updTaken(updTaken)
  );

  function automatic int entryOf(logic [31:0] pc, logic [1:0] h);
    return int'(pc[7:2]) * 4 + int'(h);
  endfunction

  function automatic logic [1:0] nextCnt(logic [1:0] c, bit t);
    if (t)  return (c == 2'b11) ? c : c + 2'b01;
    return (c == 2'b00) ? c : c - 2'b01;
  endfunction

  task automatic summary();
    if (!summaryDone) begin
      summaryDone = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", checkCnt, failCnt);
    end
  endtask

  // one cycle: drive at falling edge, check lookup, then let the update land
  task automatic step(bit uv, logic [31:0] upc, logic [1:0] uh, bit ut,
                      logic [31:0] lpc, string tag);
    logic expPred;
    @(negedge clk);
    updValid = uv; updPc = upc; updHist = uh; updTaken = ut; lookupPc = lpc;
    #1;
    expPred = expTbl[entryOf(lpc, expHist)][1];
    checkCnt++;
    if (predTaken !== expPred) begin
      failCnt++;
      $display("FAIL %s predTaken pc=%h actual=%b expected=%b", tag, lpc, predTaken, expPred);
    end
    checkCnt++;
    if (predHist !== expHist) begin
      failCnt++;
      $display("FAIL %s predHist actual=%b expected=%b", tag, predHist, expHist);
    end
    @(posedge clk);
    if (uv) begin
      expTbl[entryOf(upc, uh)] = nextCnt(expTbl[entryOf(upc, uh)], ut);
      expHist = {expHist[0], ut};
    end
  endtask

  localparam logic [31:0] PC_A  = 32'h0000_1040;
  localparam logic [31:0] PC_B  = 32'h0000_2088;
  localparam logic [31:0] PC_A2 = 32'h0077_1040;  // same index bits as PC_A

  initial begin
    #(200000 * 8);
    failCnt++;
    $display("FAIL watchdog expired actual=running expected=done");
    summary();
    $finish;
  end

  initial begin
    logic [31:0] pool [8];
    void'($urandom(32'd91357));
    for (int i = 0; i < ROWS*4; i++) expTbl[i] = 2'b01;
    expHist = 2'b00;
    pool[0] = PC_A; pool[1] = PC_B; pool[2] = PC_A2; pool[3] = 32'h0000_00fc;
    pool[4] = 32'h1234_5600; pool[5] = 32'h0000_0104; pool[6] = 32'hdead_be04;
    pool[7] = 32'h0000_0040;

    repeat (2) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;

    // R1: reset state, several rows, no updates
    step(0, 0, 0, 0, PC_A, "R1");
    step(0, 0, 0, 0, PC_B, "R1");
    step(0, 0, 0, 0, 32'hffff_fffc, "R1");

    // R3/R7: drive counter [A,col3] to strong taken while history fills with ones
    step(1, PC_A, 2'd3, 1, PC_A, "R3");
    step(1, PC_A, 2'd3, 1, PC_A, "R3");
    step(1, PC_A, 2'd3, 1, PC_A, "R3");   // already 11: saturates
    step(0, 0, 0, 0, PC_A, "R2");          // history 3, counter 11 -> taken
    // R5: other rows and columns were not touched
    step(0, 0, 0, 0, PC_B, "R5");
    // R8: an alias of PC_A sees the same counter
    step(0, 0, 0, 0, PC_A2, "R8");

    // R7: one miss from 11 keeps taken, a second miss flips it
    step(1, PC_A, 2'd3, 0, PC_A, "R7");    // -> 10, history 2
    step(1, PC_B, 2'd2, 1, PC_A, "R6");    // history 1
    step(1, PC_B, 2'd1, 1, PC_A, "R6");    // history 3
    step(0, 0, 0, 0, PC_A, "R7");          // counter 10 -> still taken
    step(1, PC_A, 2'd3, 0, PC_A, "R7");    // -> 01
    step(1, PC_B, 2'd2, 1, PC_A, "R6");
    step(1, PC_B, 2'd1, 1, PC_A, "R6");
    step(0, 0, 0, 0, PC_A, "R7");          // counter 01 -> not taken

    // R4: lower [B,col0] to the floor and beyond
    step(1, PC_B, 2'd0, 0, PC_B, "R4");
    step(1, PC_B, 2'd0, 0, PC_B, "R4");
    step(1, PC_B, 2'd0, 0, PC_B, "R4");
    step(1, PC_B, 2'd0, 1, PC_B, "R4");    // from 00 back to 01
    step(0, 0, 0, 0, PC_B, "R6");          // history held

    // R9: same-cycle update and lookup of the same entry
    step(1, PC_A2, expHist, 1, PC_A2, "R9");
    step(1, PC_A2, expHist, 1, PC_A2, "R9");
    step(0, 0, 0, 0, PC_A2, "R9");

    // R2/R5/R6: random traffic over a small address pool
    for (int n = 0; n < 4000; n++) begin
      logic [31:0] upc;
      logic [31:0] lpc;
      logic [1:0]  uh;
      bit uv;
      bit ut;
      uv  = ($urandom_range(0, 3) != 0);
      upc = pool[$urandom_range(0, 7)];
      lpc = pool[$urandom_range(0, 7)];
      uh  = ($urandom_range(0, 9) < 7) ? expHist : 2'($urandom_range(0, 3));
      ut  = ($urandom_range(0, 9) < 6);
      step(uv, upc, uh, ut, lpc, "R2");
    end

    updValid = 1'b0;
    summary();
    $finish;
  end

endmodule